// File: doc/BRIEF.md
# Clock Source and Reset Controller

This block sits next to the analog clock circuitry and decides which source feeds the reference clock path and the main clock. The sources are the input oscillator divided by 16, the undivided input oscillator, the PLL output and an alternate clock. The block drives select codes for an external glitch-free multiplexer, a pre-divide-by-2 select and the PLL multiplier and divisor settings. It samples the PLL-lock and regulator-OK status through synchronisers. Switching to the PLL is held off until both of those are true.

The block also records why the chip was reset and can request a software reset. A write to a halt bit produces a one-cycle reset request, but only when two enable bits are already set. Two interrupt sources can reach a single interrupt line, each through its own mask bit. One fires when the PLL locks, the other when the reference source changes.

Software reaches four 16-bit registers through a simple single-cycle bus. `por_n` is an asynchronous power-on reset that clears everything. `sys_rst_n` is a synchronous system reset. It clears the control, PLL and pending state but keeps the reset-cause flags.

Top module: `clksrc_rst_ctrl`

## Requirements
- R1: With CTRL (address 0) bit 0 clear, `ref_sel_o` is 0 (input/16). With bit 0 set, it is 1 (undivided input), or 2 (PLL) when the PLL is permitted. Outside low-power wait, `mclk_sel_o` equals `ref_sel_o`.
- R2: The PLL is permitted only while CTRL bit 1 (PLL request), the synchronised `pll_lock_i` and the synchronised `vreg_ok_i` are all 1. When either status drops, the selection falls back to code 1.
- R3: Writing 1 to MODE (address 2) bit 0 raises `rst_req_o` for exactly one cycle, and sets STAT bit 3. This happens only if CTRL bit 2 (halt enable) and CTRL bit 3 (software-reset enable) are both set. Otherwise the write has no effect.
- R4: `pre_div2_o` follows CTRL bit 4.
- R5: STAT (address 1) holds sticky flags: bit 2 for a watchdog reset (`wdg_rst_i`), bit 3 for a software reset, and bit 4 for a low-voltage reset (`lvd_rst_i`). A system reset (`sys_rst_n`) leaves them unchanged. They clear only on `por_n` or on a write of 1 to the bit.
- R6: `irq_o` is high when STAT bit 0 (lock pending) and CTRL bit 7 are both set, or when STAT bit 1 (switch pending) and CTRL bit 8 are both set. A pending bit with a clear mask does not reach `irq_o`.
- R7: When CTRL bit 5 (low-power wait) is set and `wfi_i` is high, `mclk_sel_o` is 3 (alternate) if CTRL bit 6 is set, and 0 (input/16) otherwise.
- R8: PLL register (address 3) bits 1:0 select the multiplier, with codes 0 to 3 giving 12, 16, 20 and 24 on `pll_mul_o`. Bits 4:2 set the divisor 1 to 7 on `pll_div_o`. A divisor of 0 is ignored, and the reset value is 1.
- R9: STAT pending bits and flags clear on a write of 1. If a set event falls in the same cycle as the clear, the bit stays set.
- R10: Lock pending (STAT bit 0) sets on a rising edge of the synchronised lock input only. A lock input that stays high does not set it again.
- R11: Switch pending (STAT bit 1) sets whenever the registered `ref_sel_o` changes value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_n | input | 1 | Synchronous system reset, active low, keeps flags |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| pll_lock_i | input | 1 | PLL locked status, asynchronous |
| vreg_ok_i | input | 1 | Main regulator OK status, asynchronous |
| wfi_i | input | 1 | Core is in wait-for-interrupt |
| wdg_rst_i | input | 1 | Watchdog reset event, one cycle |
| lvd_rst_i | input | 1 | Low-voltage reset event, one cycle |
| ref_sel_o | output | 2 | Reference path source code |
| mclk_sel_o | output | 2 | Main clock source code |
| pre_div2_o | output | 1 | Halve the input oscillator |
| pll_mul_o | output | 5 | PLL multiplier factor |
| pll_div_o | output | 3 | PLL output divisor |
| rst_req_o | output | 1 | Software reset request pulse |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with its defaults: a two-stage synchroniser and a 16-bit data bus. With two stages, the cycle in which a lock rising edge sets the pending bit is fixed. That lets the bench line up a write-1-to-clear on exactly that edge and check the set-over-clear priority. The 16-bit bus covers the full nine-bit control field, including both interrupt mask bits.

// File: rtl/csr_pkg.sv
package csr_pkg;

    typedef enum logic [1:0] {
        SRC_DIV16  = 2'd0,
        SRC_DIRECT = 2'd1,
        SRC_PLL    = 2'd2,
        SRC_ALT    = 2'd3
    } src_e;

    typedef struct packed {
        logic sw_ie;
        logic lock_ie;
        logic wfi_alt;
        logic wfi_lp;
        logic pre_div2;
        logic srst_en;
        logic halt_en;
        logic pll_req;
        logic full_rate;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_MODE = 2'd2;
    localparam logic [1:0] A_PLL  = 2'd3;

    localparam int MUL_BASE = 12;
    localparam int MUL_STEP = 4;

    function automatic logic [4:0] mul_factor(input logic [1:0] code);
        return 5'(MUL_BASE + MUL_STEP * int'(code));
    endfunction

endpackage

// File: rtl/csr_sync.sv
module csr_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_comb stage_d[i] = d;
        end else begin : g_next
            always_comb stage_d[i] = stage_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= '0;
            else        stage_q[i] <= stage_d[i];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/csr_clksel.sv
module csr_clksel
    import csr_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst_n,
    input  logic full_rate,
    input  logic pll_req,
    input  logic lock_s,
    input  logic vok_s,
    input  logic wfi_lp,
    input  logic wfi_alt,
    input  logic wfi_i,
    output src_e ref_sel,
    output src_e mclk_sel,
    output logic switch_evt
);
    typedef struct packed {
        src_e ref_src;
        src_e mclk_src;
    } sel_t;

    sel_t sel_d, sel_q;
    logic pll_ok;

    always_comb begin
        sel_d  = sel_q;
        pll_ok = pll_req && lock_s && vok_s;
        if (!full_rate)  sel_d.ref_src = SRC_DIV16;
        else if (pll_ok) sel_d.ref_src = SRC_PLL;
        else             sel_d.ref_src = SRC_DIRECT;

        if (wfi_lp && wfi_i) sel_d.mclk_src = wfi_alt ? SRC_ALT : SRC_DIV16;
        else                 sel_d.mclk_src = sel_d.ref_src;

        if (!sys_rst_n) begin
            sel_d.ref_src  = SRC_DIV16;
            sel_d.mclk_src = SRC_DIV16;
        end
        switch_evt = (sel_d.ref_src != sel_q.ref_src);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sel_q.ref_src  <= SRC_DIV16;
            sel_q.mclk_src <= SRC_DIV16;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign ref_sel  = sel_q.ref_src;
    assign mclk_sel = sel_q.mclk_src;

    // R2: PLL only after lock and regulator OK were both seen with a request
    p_pll_gated_r2: assert property (@(posedge clk) disable iff (!por_n)
        (sel_q.ref_src == SRC_PLL) |-> $past(pll_req && lock_s && vok_s));

    // R7: low-power wait picks alternate or divided clock
    p_wfi_clock_r7: assert property (@(posedge clk) disable iff (!por_n)
        $past(wfi_lp && wfi_i && sys_rst_n) |->
        (sel_q.mclk_src == ($past(wfi_alt) ? SRC_ALT : SRC_DIV16)));
endmodule

// File: rtl/csr_regs.sv
module csr_regs
    import csr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          sys_rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          lock_s,
    input  logic          vok_s,
    input  logic          wfi_i,
    input  logic          wdg_rst_i,
    input  logic          lvd_rst_i,
    input  logic          switch_evt,
    output ctrl_t         ctrl,
    output logic [1:0]    mul_code,
    output logic [2:0]    div_val,
    output logic          rst_req,
    output logic          irq
);
    typedef struct packed {
        ctrl_t      ctrl;
        logic       lock_pend;
        logic       sw_pend;
        logic       wdg_f;
        logic       soft_f;
        logic       lvd_f;
        logic [1:0] mul;
        logic [2:0] div;
        logic       lock_prev;
        logic       rst_req;
    } st_t;

    st_t  st_d, st_q;
    logic wr, lock_rise, halt_ok, clr_stat;

    always_comb begin
        st_d           = st_q;
        st_d.rst_req   = 1'b0;
        st_d.lock_prev = lock_s;
        wr        = bus_sel && bus_wr;
        lock_rise = lock_s && !st_q.lock_prev;
        clr_stat  = wr && (bus_addr == A_STAT);
        halt_ok   = wr && (bus_addr == A_MODE) && bus_wdata[0]
                    && st_q.ctrl.halt_en && st_q.ctrl.srst_en;

        if (wr && bus_addr == A_CTRL) st_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        if (clr_stat) begin
            if (bus_wdata[0]) st_d.lock_pend = 1'b0;
            if (bus_wdata[1]) st_d.sw_pend   = 1'b0;
            if (bus_wdata[2]) st_d.wdg_f     = 1'b0;
            if (bus_wdata[3]) st_d.soft_f    = 1'b0;
            if (bus_wdata[4]) st_d.lvd_f     = 1'b0;
        end
        if (wr && bus_addr == A_PLL) begin
            st_d.mul = bus_wdata[1:0];
            if (bus_wdata[4:2] != 3'd0) st_d.div = bus_wdata[4:2];
        end

        // set events win over a clear in the same cycle
        if (lock_rise)  st_d.lock_pend = 1'b1;
        if (switch_evt) st_d.sw_pend   = 1'b1;
        if (wdg_rst_i)  st_d.wdg_f     = 1'b1;
        if (lvd_rst_i)  st_d.lvd_f     = 1'b1;
        if (halt_ok) begin
            st_d.soft_f  = 1'b1;
            st_d.rst_req = 1'b1;
        end

        // system reset spares the cause flags
        if (!sys_rst_n) begin
            st_d.ctrl      = '0;
            st_d.lock_pend = 1'b0;
            st_d.sw_pend   = 1'b0;
            st_d.mul       = 2'd0;
            st_d.div       = 3'd1;
            st_d.rst_req   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q     <= '0;
            st_q.div <= 3'd1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata[CTRL_W-1:0] = st_q.ctrl;
            A_STAT:  bus_rdata[6:0] = {vok_s, lock_s, st_q.lvd_f, st_q.soft_f,
                                       st_q.wdg_f, st_q.sw_pend, st_q.lock_pend};
            A_MODE:  bus_rdata[1:0] = {wfi_i, 1'b0};
            default: bus_rdata[4:0] = {st_q.div, st_q.mul};
        endcase
    end

    assign ctrl     = st_q.ctrl;
    assign mul_code = st_q.mul;
    assign div_val  = st_q.div;
    assign rst_req  = st_q.rst_req;
    assign irq      = (st_q.lock_pend && st_q.ctrl.lock_ie)
                   || (st_q.sw_pend && st_q.ctrl.sw_ie);

    // R3: a reset request needs both enables in the cycle of the halt write
    p_srst_enables_r3: assert property (@(posedge clk) disable iff (!por_n)
        st_q.rst_req |-> $past(st_q.ctrl.halt_en && st_q.ctrl.srst_en));

    // R3: request lasts a single cycle
    p_srst_pulse_r3: assert property (@(posedge clk) disable iff (!por_n)
        st_q.rst_req |=> !st_q.rst_req);

    // R5: watchdog flag falls only through a write of 1
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!por_n)
        $fell(st_q.wdg_f) |-> $past(clr_stat && bus_wdata[2]));

    // R9: set beats clear in the same cycle
    p_set_priority_r9: assert property (@(posedge clk) disable iff (!por_n)
        (lock_rise && clr_stat && bus_wdata[0] && sys_rst_n) |=> st_q.lock_pend);

    // R10: lock pending rises only after a lock edge
    p_lock_edge_r10: assert property (@(posedge clk) disable iff (!por_n)
        $rose(st_q.lock_pend) |-> $past(lock_rise));
endmodule

// File: rtl/clksrc_rst_ctrl.sv
module clksrc_rst_ctrl
    import csr_pkg::*;
#(
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          sys_rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          pll_lock_i,
    input  logic          vreg_ok_i,
    input  logic          wfi_i,
    input  logic          wdg_rst_i,
    input  logic          lvd_rst_i,
    output logic [1:0]    ref_sel_o,
    output logic [1:0]    mclk_sel_o,
    output logic          pre_div2_o,
    output logic [4:0]    pll_mul_o,
    output logic [2:0]    pll_div_o,
    output logic          rst_req_o,
    output logic          irq_o
);
    logic [1:0] stat_s;
    logic       switch_evt;
    ctrl_t      ctrl;
    src_e       ref_sel, mclk_sel;
    logic [1:0] mul_code;

    csr_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     ({vreg_ok_i, pll_lock_i}),
        .q     (stat_s)
    );

    csr_clksel u_sel (
        .clk        (clk),
        .por_n      (por_n),
        .sys_rst_n  (sys_rst_n),
        .full_rate  (ctrl.full_rate),
        .pll_req    (ctrl.pll_req),
        .lock_s     (stat_s[0]),
        .vok_s      (stat_s[1]),
        .wfi_lp     (ctrl.wfi_lp),
        .wfi_alt    (ctrl.wfi_alt),
        .wfi_i      (wfi_i),
        .ref_sel    (ref_sel),
        .mclk_sel   (mclk_sel),
        .switch_evt (switch_evt)
    );

    csr_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .por_n      (por_n),
        .sys_rst_n  (sys_rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .lock_s     (stat_s[0]),
        .vok_s      (stat_s[1]),
        .wfi_i      (wfi_i),
        .wdg_rst_i  (wdg_rst_i),
        .lvd_rst_i  (lvd_rst_i),
        .switch_evt (switch_evt),
        .ctrl       (ctrl),
        .mul_code   (mul_code),
        .div_val    (pll_div_o),
        .rst_req    (rst_req_o),
        .irq        (irq_o)
    );

    assign ref_sel_o  = ref_sel;
    assign mclk_sel_o = mclk_sel;
    assign pre_div2_o = ctrl.pre_div2;
    assign pll_mul_o  = mul_factor(mul_code);
endmodule

// File: tb/sim_clksrc_rst_ctrl.sv
module sim_clksrc_rst_ctrl;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, sys_rst_n = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        pll_lock_i = 1'b0, vreg_ok_i = 1'b0, wfi_i = 1'b0;
    logic        wdg_rst_i = 1'b0, lvd_rst_i = 1'b0;
    logic [1:0]  ref_sel_o, mclk_sel_o;
    logic        pre_div2_o, rst_req_o, irq_o;
    logic [4:0]  pll_mul_o;
    logic [2:0]  pll_div_o;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    clksrc_rst_ctrl u0 (.*);

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 reset ref", 16'(ref_sel_o), 16'd0);
        check("R1 reset mclk", 16'(mclk_sel_o), 16'd0);
        check("R3 reset req", 16'(rst_req_o), 16'd0);
        check("R6 reset irq", 16'(irq_o), 16'd0);
        check("R8 reset mul", 16'(pll_mul_o), 16'd12);
        check("R8 reset div", 16'(pll_div_o), 16'd1);
        rd(2'd1, v); check("R5 reset stat", v, 16'd0);
    endtask

    task automatic t_refsel();
        wr(2'd0, 16'h0011); wait_cyc(3);
        check("R1 direct ref", 16'(ref_sel_o), 16'd1);
        check("R1 direct mclk", 16'(mclk_sel_o), 16'd1);
        check("R4 prediv on", 16'(pre_div2_o), 16'd1);
        wr(2'd0, 16'h0000); wait_cyc(3);
        check("R1 div16 ref", 16'(ref_sel_o), 16'd0);
        check("R4 prediv off", 16'(pre_div2_o), 16'd0);
    endtask

    task automatic t_pll_gate();
        vreg_ok_i = 1'b1;
        wr(2'd0, 16'h0003); wait_cyc(5);
        check("R2 no lock", 16'(ref_sel_o), 16'd1);
        pll_lock_i = 1'b1; wait_cyc(5);
        check("R2 pll on", 16'(ref_sel_o), 16'd2);
        check("R2 mclk pll", 16'(mclk_sel_o), 16'd2);
        vreg_ok_i = 1'b0; wait_cyc(5);
        check("R2 vreg drop", 16'(ref_sel_o), 16'd1);
        vreg_ok_i = 1'b1; wait_cyc(5);
        check("R2 vreg back", 16'(ref_sel_o), 16'd2);
        pll_lock_i = 1'b0;
        wr(2'd0, 16'h0000); wait_cyc(5);
        wr(2'd1, 16'h001F);
    endtask

    task automatic t_swrst();
        logic [15:0] v;
        wr(2'd0, 16'h0004);
        wr(2'd2, 16'h0001);
        check("R3 one enable", 16'(rst_req_o), 16'd0);
        rd(2'd1, v); check("R3 no flag", 16'(v[3]), 16'd0);
        wr(2'd0, 16'h000C);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 16'h0001;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R3 req pulse", 16'(rst_req_o), 16'd1);
        @(negedge clk);
        check("R3 req ends", 16'(rst_req_o), 16'd0);
        sys_rst_n = 1'b0; @(negedge clk); sys_rst_n = 1'b1;
        rd(2'd1, v); check("R5 soft kept", 16'(v[3]), 16'd1);
        rd(2'd0, v); check("R5 ctrl cleared", v, 16'd0);
        wr(2'd1, 16'h0008);
        rd(2'd1, v); check("R5 soft clear", 16'(v[3]), 16'd0);
    endtask

    task automatic t_flags();
        logic [15:0] v;
        @(negedge clk); wdg_rst_i = 1'b1; lvd_rst_i = 1'b1;
        @(negedge clk); wdg_rst_i = 1'b0; lvd_rst_i = 1'b0;
        wait_cyc(2);
        rd(2'd1, v);
        check("R5 wdg set", 16'(v[2]), 16'd1);
        check("R5 lvd set", 16'(v[4]), 16'd1);
        wr(2'd1, 16'h0004);
        rd(2'd1, v);
        check("R5 wdg clr", 16'(v[2]), 16'd0);
        check("R5 lvd kept", 16'(v[4]), 16'd1);
        wr(2'd1, 16'h0010);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        pll_lock_i = 1'b1; wait_cyc(5);
        rd(2'd1, v); check("R10 lock pend", 16'(v[0]), 16'd1);
        check("R6 masked", 16'(irq_o), 16'd0);
        wr(2'd0, 16'h0080);
        check("R6 lock irq", 16'(irq_o), 16'd1);
        wr(2'd1, 16'h0001);
        check("R9 w1c irq", 16'(irq_o), 16'd0);
        wait_cyc(5);
        rd(2'd1, v); check("R10 level no set", 16'(v[0]), 16'd0);
        wr(2'd0, 16'h0101); wait_cyc(3);
        rd(2'd1, v); check("R11 switch pend", 16'(v[1]), 16'd1);
        check("R6 switch irq", 16'(irq_o), 16'd1);
        wr(2'd1, 16'h0002);
        check("R11 cleared", 16'(irq_o), 16'd0);
        pll_lock_i = 1'b0;
        wr(2'd0, 16'h0000); wait_cyc(5);
        wr(2'd1, 16'h001F);
    endtask

    task automatic t_priority();
        logic [15:0] v;
        @(negedge clk); pll_lock_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h0001;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(2'd1, v); check("R9 set wins", 16'(v[0]), 16'd1);
        wr(2'd1, 16'h0001);
        rd(2'd1, v); check("R9 plain clear", 16'(v[0]), 16'd0);
        pll_lock_i = 1'b0; wait_cyc(4);
    endtask

    task automatic t_wfi();
        wfi_i = 1'b1;
        wr(2'd0, 16'h0021); wait_cyc(3);
        check("R7 wfi div16", 16'(mclk_sel_o), 16'd0);
        check("R7 ref keeps", 16'(ref_sel_o), 16'd1);
        wr(2'd0, 16'h0061); wait_cyc(3);
        check("R7 wfi alt", 16'(mclk_sel_o), 16'd3);
        wfi_i = 1'b0; wait_cyc(3);
        check("R7 awake", 16'(mclk_sel_o), 16'd1);
        wfi_i = 1'b1;
        wr(2'd0, 16'h0041); wait_cyc(3);
        check("R7 lp off", 16'(mclk_sel_o), 16'd1);
        wfi_i = 1'b0;
        wr(2'd0, 16'h0000); wait_cyc(3);
        wr(2'd1, 16'h001F);
    endtask

    task automatic t_pllcfg();
        logic [15:0] v;
        wr(2'd3, 16'h0017);
        check("R8 mul 24", 16'(pll_mul_o), 16'd24);
        check("R8 div 5", 16'(pll_div_o), 16'd5);
        wr(2'd3, 16'h0001);
        check("R8 mul 16", 16'(pll_mul_o), 16'd16);
        check("R8 div zero kept", 16'(pll_div_o), 16'd5);
        wr(2'd3, 16'h000A);
        check("R8 mul 20", 16'(pll_mul_o), 16'd20);
        rd(2'd3, v); check("R8 readback", v, 16'h000A);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait_cyc(3);
        por_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_refsel();
        t_pll_gate();
        t_swrst();
        t_flags();
        t_irq();
        t_priority();
        t_wfi();
        t_pllcfg();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule